// File: doc/BRIEF.md
# Burst-Count Limited FIFO Chunker

This block moves a byte stream of arbitrary length between a local stream interface and the data FIFO register of a device. It sits on top of a register transaction master, which frames each request onto the serial link. For every chunk the block first reads the device's 32-bit status register through the master. From that word it takes the burst count, which is the number of bytes the device will accept or supply right now. It then issues one data FIFO transaction no longer than the bytes still outstanding, the burst count or the 64-byte frame cap, whichever is smallest.

A transfer starts with a one-cycle `start` pulse that carries a byte total and a direction. When `dir` is 0, bytes are pulled from the upstream stream and written to the device. When `dir` is 1, bytes are read from the device and pushed out on the downstream stream. A burst count of zero means the device is busy: the block reads the status register again and issues no data transaction. When the whole total has moved, a one-cycle `o_done` pulse is raised.

Top module: `burst_chunker`

## Requirements
- R1: While reset is high and in the first cycle after it, `xm_cmd_valid`, `o_done`, `dn_tvalid` and `up_tready` are all low.
- R2: Each data transaction is preceded by a status read: a read command (`xm_cmd_read`=1) of length 4 at address `BASE`+0x18.
- R3: The four status bytes return least significant first. The burst count is bits 23:8 of the assembled word, and the other bits have no effect on chunk sizing.
- R4: When the burst count is zero, the next command is another status read; no data transaction is issued on a zero burst.
- R5: A data transaction targets `BASE`+0x24 with `xm_cmd_read` equal to `dir`, and its length `xm_cmd_len` (a byte count, 1 to 64) equals min(bytes remaining, burst count, 64).
- R6: Write payload bytes are taken from the upstream stream in order. Read payload bytes appear on the downstream stream in order. Status bytes never appear on the downstream stream.
- R7: Chunks repeat until the total has moved. Then `o_done` is high for exactly one cycle and no command is pending.
- R8: A start with a total of zero raises `o_done` in the cycle after `start` is sampled and issues no command.
- R9: A command whose `xm_cmd_valid` is high while `xm_cmd_ready` is low stays valid with unchanged address, direction and length in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| dir | input | 1 | 0: write to device, 1: read from device |
| total_len | input | LEN_W | Byte total of the transfer |
| o_done | output | 1 | One-cycle pulse at the end of a transfer |
| up_tdata | input | 8 | Upstream byte for device writes |
| up_tvalid | input | 1 | Upstream byte valid |
| up_tready | output | 1 | Upstream byte accepted |
| dn_tdata | output | 8 | Downstream byte from device reads |
| dn_tvalid | output | 1 | Downstream byte valid |
| xm_cmd_valid | output | 1 | Transaction request to the master |
| xm_cmd_ready | input | 1 | Master accepts the request |
| xm_cmd_read | output | 1 | Request is a register read |
| xm_cmd_addr | output | ADDR_W | Register address of the request |
| xm_cmd_len | output | 7 | Byte length of the request (1 to 64) |
| xm_wdata | output | 8 | Write payload byte to the master |
| xm_wvalid | output | 1 | Write payload byte valid |
| xm_wready | input | 1 | Master accepts the write byte |
| xm_rdata | input | 8 | Read byte returned by the master |
| xm_rvalid | input | 1 | Read byte valid |

## Verification
The bench builds the block with `LEN_W`=10 and `BASE`=0. With these values every total from 0 to 150 can be swept in both directions, together with long totals up to the 1023 ceiling of the length field. The device model draws burst counts arithmetically. The values include zeros, small values, values between 64 and 70 and values with bit 15 set, so each of the three limits in turn decides a chunk size and the retry path is exercised many times. The model also sets junk in the status bits outside the burst field, and it throttles the ready and valid signals on a cycle pattern so that held commands and stalled streams are covered.

// File: rtl/burst_chunker_pkg.sv
package burst_chunker_pkg;

    localparam int unsigned FRAME_CAP = 64;
    localparam int unsigned CHUNK_W   = $clog2(FRAME_CAP + 1);
    localparam int unsigned STS_LANES = 4;
    localparam int unsigned BURST_W   = 16;

    localparam logic [11:0] STS_OFS  = 12'h018;
    localparam logic [11:0] FIFO_OFS = 12'h024;

    typedef struct packed {
        logic [7:0]         upper;
        logic [BURST_W-1:0] burst;
        logic [7:0]         lower;
    } sts_word_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STS_REQ,
        PH_STS_RX,
        PH_SIZE,
        PH_DAT_REQ,
        PH_DAT_XFER
    } phase_e;

endpackage

// File: rtl/sts_word_asm.sv
module sts_word_asm #(
    parameter int unsigned LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               bvalid,
    input  logic [7:0]         bdata,
    output logic [LANES*8-1:0] word,
    output logic               last
);
    localparam int unsigned IW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= '0;
        end else if (bvalid) begin
            if (idx_q == IW'(LANES - 1)) idx_q <= '0;
            else                         idx_q <= idx_q + IW'(1);
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)                                lane_q <= '0;
            else if (bvalid && idx_q == IW'(g))     lane_q <= bdata;
        end
        assign word[g*8 +: 8] = lane_q;
    end

    assign last = bvalid && (idx_q == IW'(LANES - 1));

endmodule

// File: rtl/chunk_sizer.sv
module chunk_sizer #(
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned BURST_W = 16,
    parameter int unsigned CAP     = 64,
    parameter int unsigned CHUNK_W = 7
) (
    input  logic [LEN_W-1:0]   remaining,
    input  logic [BURST_W-1:0] burst,
    output logic [CHUNK_W-1:0] chunk,
    output logic               burst_zero
);
    localparam int unsigned CW0 = (LEN_W > BURST_W) ? LEN_W : BURST_W;
    localparam int unsigned CW  = (CW0 > CHUNK_W) ? CW0 : CHUNK_W;

    logic [CW-1:0] r_w, b_w, c_w, m1, m2;

    always_comb begin
        r_w = CW'(remaining);
        b_w = CW'(burst);
        c_w = CW'(CAP);
        m1  = (r_w < b_w) ? r_w : b_w;
        m2  = (m1 < c_w) ? m1 : c_w;
    end

    assign chunk      = m2[CHUNK_W-1:0];
    assign burst_zero = (burst == '0);

endmodule

// File: rtl/xfer_tally.sv
module xfer_tally #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (inc)     cnt_q <= cnt_q + W'(1);
    end

    assign last = inc && ((cnt_q + W'(1)) == limit);

endmodule

// File: rtl/burst_chunker.sv
module burst_chunker
    import burst_chunker_pkg::*;
#(
    parameter int unsigned       LEN_W  = 16,
    parameter int unsigned       ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                dir,
    input  logic [LEN_W-1:0]    total_len,
    output logic                o_done,
    input  logic [7:0]          up_tdata,
    input  logic                up_tvalid,
    output logic                up_tready,
    output logic [7:0]          dn_tdata,
    output logic                dn_tvalid,
    output logic                xm_cmd_valid,
    input  logic                xm_cmd_ready,
    output logic                xm_cmd_read,
    output logic [ADDR_W-1:0]   xm_cmd_addr,
    output logic [CHUNK_W-1:0]  xm_cmd_len,
    output logic [7:0]          xm_wdata,
    output logic                xm_wvalid,
    input  logic                xm_wready,
    input  logic [7:0]          xm_rdata,
    input  logic                xm_rvalid
);
    localparam logic [ADDR_W-1:0] STS_ADDR  = BASE + ADDR_W'(STS_OFS);
    localparam logic [ADDR_W-1:0] FIFO_ADDR = BASE + ADDR_W'(FIFO_OFS);

    phase_e             phase_q;
    logic               dir_q;
    logic [LEN_W-1:0]   rem_q;
    logic [CHUNK_W-1:0] chunk_q;
    logic               done_q;

    sts_word_t          sts_w;
    logic               sts_last;
    logic [CHUNK_W-1:0] chunk_w;
    logic               burst_zero;
    logic               byte_evt;
    logic               tally_last;

    logic in_sts_rx, in_xfer;
    assign in_sts_rx = (phase_q == PH_STS_RX);
    assign in_xfer   = (phase_q == PH_DAT_XFER);

    assign byte_evt = in_xfer && (dir_q ? xm_rvalid : (xm_wvalid && xm_wready));

    sts_word_asm #(.LANES(STS_LANES)) u_asm (
        .clk    (clk),
        .rst    (rst),
        .clear  (phase_q == PH_STS_REQ),
        .bvalid (in_sts_rx && xm_rvalid),
        .bdata  (xm_rdata),
        .word   (sts_w),
        .last   (sts_last)
    );

    chunk_sizer #(
        .LEN_W   (LEN_W),
        .BURST_W (BURST_W),
        .CAP     (FRAME_CAP),
        .CHUNK_W (CHUNK_W)
    ) u_size (
        .remaining  (rem_q),
        .burst      (sts_w.burst),
        .chunk      (chunk_w),
        .burst_zero (burst_zero)
    );

    xfer_tally #(.W(CHUNK_W)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .clear (phase_q == PH_DAT_REQ),
        .inc   (byte_evt),
        .limit (chunk_q),
        .last  (tally_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            dir_q   <= 1'b0;
            rem_q   <= '0;
            chunk_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        dir_q <= dir;
                        rem_q <= total_len;
                        if (total_len == '0) done_q  <= 1'b1;
                        else                 phase_q <= PH_STS_REQ;
                    end
                end
                PH_STS_REQ: begin
                    if (xm_cmd_ready) phase_q <= PH_STS_RX;
                end
                PH_STS_RX: begin
                    if (sts_last) phase_q <= PH_SIZE;
                end
                PH_SIZE: begin
                    if (burst_zero) begin
                        phase_q <= PH_STS_REQ;
                    end else begin
                        chunk_q <= chunk_w;
                        phase_q <= PH_DAT_REQ;
                    end
                end
                PH_DAT_REQ: begin
                    if (xm_cmd_ready) phase_q <= PH_DAT_XFER;
                end
                PH_DAT_XFER: begin
                    if (tally_last) begin
                        rem_q <= rem_q - LEN_W'(chunk_q);
                        if (rem_q == LEN_W'(chunk_q)) begin
                            done_q  <= 1'b1;
                            phase_q <= PH_IDLE;
                        end else begin
                            phase_q <= PH_STS_REQ;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    logic sts_req;
    assign sts_req      = (phase_q == PH_STS_REQ);
    assign xm_cmd_valid = sts_req || (phase_q == PH_DAT_REQ);
    assign xm_cmd_read  = sts_req || dir_q;
    assign xm_cmd_addr  = sts_req ? STS_ADDR : FIFO_ADDR;
    assign xm_cmd_len   = sts_req ? CHUNK_W'(STS_LANES) : chunk_q;

    assign xm_wdata  = up_tdata;
    assign xm_wvalid = in_xfer && !dir_q && up_tvalid;
    assign up_tready = in_xfer && !dir_q && xm_wready;

    assign dn_tdata  = xm_rdata;
    assign dn_tvalid = in_xfer && dir_q && xm_rvalid;

    assign o_done = done_q;

endmodule

// File: rtl/burst_chunker_chk.sv
module burst_chunker_chk
    import burst_chunker_pkg::*;
#(
    parameter int unsigned       ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input logic               clk,
    input logic               rst,
    input logic               o_done,
    input logic               dn_tvalid,
    input logic               xm_cmd_valid,
    input logic               xm_cmd_ready,
    input logic               xm_cmd_read,
    input logic [ADDR_W-1:0]  xm_cmd_addr,
    input logic [CHUNK_W-1:0] xm_cmd_len
);
    localparam logic [ADDR_W-1:0] STS_A  = BASE + ADDR_W'(STS_OFS);
    localparam logic [ADDR_W-1:0] FIFO_A = BASE + ADDR_W'(FIFO_OFS);

    // R2
    sts_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (xm_cmd_valid && xm_cmd_addr == STS_A) |-> (xm_cmd_read && xm_cmd_len == CHUNK_W'(4)));

    // R5
    fifo_len_chk: assert property (@(posedge clk) disable iff (rst)
        (xm_cmd_valid && xm_cmd_addr == FIFO_A) |->
            (xm_cmd_len != '0 && xm_cmd_len <= CHUNK_W'(FRAME_CAP)));

    // R5
    addr_set_chk: assert property (@(posedge clk) disable iff (rst)
        xm_cmd_valid |-> (xm_cmd_addr == STS_A || xm_cmd_addr == FIFO_A));

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xm_cmd_valid && !xm_cmd_ready) |=>
            (xm_cmd_valid && $stable(xm_cmd_addr) && $stable(xm_cmd_len) && $stable(xm_cmd_read)));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        o_done |-> (!xm_cmd_valid && !dn_tvalid));

endmodule

bind burst_chunker burst_chunker_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .o_done       (o_done),
    .dn_tvalid    (dn_tvalid),
    .xm_cmd_valid (xm_cmd_valid),
    .xm_cmd_ready (xm_cmd_ready),
    .xm_cmd_read  (xm_cmd_read),
    .xm_cmd_addr  (xm_cmd_addr),
    .xm_cmd_len   (xm_cmd_len)
);

// File: tb/sim_burst_chunker.sv
`timescale 1ns/1ps
module sim_burst_chunker;
    localparam int unsigned LEN_W  = 10;
    localparam int unsigned ADDR_W = 24;
    localparam logic [ADDR_W-1:0] STS_A  = 24'h000018;
    localparam logic [ADDR_W-1:0] FIFO_A = 24'h000024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic             start = 1'b0;
    logic             dir = 1'b0;
    logic [LEN_W-1:0] total_len = '0;
    logic             o_done;
    logic [7:0]       up_tdata;
    logic             up_tvalid, up_tready;
    logic [7:0]       dn_tdata;
    logic             dn_tvalid;
    logic             xm_cmd_valid, xm_cmd_ready, xm_cmd_read;
    logic [ADDR_W-1:0] xm_cmd_addr;
    logic [6:0]       xm_cmd_len;
    logic [7:0]       xm_wdata;
    logic             xm_wvalid, xm_wready;
    logic [7:0]       xm_rdata;
    logic             xm_rvalid;

    burst_chunker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .BASE('0)) u0 (
        .clk(clk), .rst(rst), .start(start), .dir(dir), .total_len(total_len),
        .o_done(o_done), .up_tdata(up_tdata), .up_tvalid(up_tvalid), .up_tready(up_tready),
        .dn_tdata(dn_tdata), .dn_tvalid(dn_tvalid), .xm_cmd_valid(xm_cmd_valid),
        .xm_cmd_ready(xm_cmd_ready), .xm_cmd_read(xm_cmd_read), .xm_cmd_addr(xm_cmd_addr),
        .xm_cmd_len(xm_cmd_len), .xm_wdata(xm_wdata), .xm_wvalid(xm_wvalid),
        .xm_wready(xm_wready), .xm_rdata(xm_rdata), .xm_rvalid(xm_rvalid)
    );

    function automatic logic [7:0] pat(input int run, input int i);
        return 8'((i * 7 + run * 3 + 1) & 255);
    endfunction

    function automatic int burst_of(input int run, input int k);
        int b;
        b = (k * 29 + run * 13 + 5) % 90;
        if (b < 10)  return 0;
        if (b >= 80) return 32768 + b;
        return b - 10;
    endfunction

    // Run control, driven by the main initial block only
    int   run_id = 0;
    int   run_total = 0;
    logic run_dir = 1'b0;
    logic clr = 1'b0;

    // Device / master model state
    int   cyc = 0;
    int   rd_left, rd_pos, rdsrc_idx, rx_idx, wr_idx, src_idx, rem_m, sts_count;
    int   burst_cur, cmd_count;
    logic rd_sts, last_good, hold_pend, hold_read;
    logic [ADDR_W-1:0] hold_addr;
    logic [6:0]  hold_len;
    logic [31:0] sts_word;
    int   mchecks = 0, mfails = 0;

    assign xm_cmd_ready = (cyc % 3) != 0;
    assign xm_wready    = (cyc % 4) != 1;
    assign up_tvalid    = (cyc % 5) != 2;
    assign up_tdata     = pat(run_id, src_idx);

    task automatic mchk(input logic ok, input string tag, input int act, input int exp);
        mchecks = mchecks + 1;
        if (!ok) begin
            mfails = mfails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst || clr) begin
            rd_left <= 0; rd_pos <= 0; rdsrc_idx <= 0; rx_idx <= 0; wr_idx <= 0;
            src_idx <= 0; rem_m <= run_total; sts_count <= 0; burst_cur <= 0;
            cmd_count <= 0; rd_sts <= 1'b0; last_good <= 1'b0; hold_pend <= 1'b0;
            hold_read <= 1'b0; hold_addr <= '0; hold_len <= '0; sts_word <= '0;
            xm_rvalid <= 1'b0; xm_rdata <= '0;
        end else begin
            // R9: held command
            if (hold_pend)
                mchk(xm_cmd_valid && xm_cmd_addr == hold_addr && xm_cmd_len == hold_len
                     && xm_cmd_read == hold_read, "R9 command held", int'(xm_cmd_len), int'(hold_len));
            hold_pend <= xm_cmd_valid && !xm_cmd_ready;
            hold_addr <= xm_cmd_addr;
            hold_len  <= xm_cmd_len;
            hold_read <= xm_cmd_read;

            // read byte return
            if (rd_left > 0) begin
                xm_rvalid <= 1'b1;
                xm_rdata  <= rd_sts ? 8'(sts_word >> (8 * rd_pos)) : pat(run_id, rdsrc_idx);
                rd_pos    <= rd_pos + 1;
                if (!rd_sts) rdsrc_idx <= rdsrc_idx + 1;
                rd_left   <= rd_left - 1;
            end else begin
                xm_rvalid <= 1'b0;
            end

            // command acceptance
            if (xm_cmd_valid && xm_cmd_ready) begin
                cmd_count <= cmd_count + 1;
                if (xm_cmd_addr == STS_A) begin
                    int b;
                    b = burst_of(run_id, sts_count);
                    mchk(xm_cmd_read && xm_cmd_len == 7'd4, "R2 status read shape",
                         int'(xm_cmd_len), 4);
                    burst_cur <= b;
                    sts_word  <= {8'(8'h5A ^ 8'(sts_count)), 16'(b), 8'(8'hC3 ^ 8'(run_id))};
                    sts_count <= sts_count + 1;
                    last_good <= (b != 0);
                    rd_left <= 4; rd_pos <= 0; rd_sts <= 1'b1;
                end else if (xm_cmd_addr == FIFO_A) begin
                    int e;
                    e = rem_m;
                    if (burst_cur < e) e = burst_cur;
                    if (64 < e) e = 64;
                    mchk(last_good, "R4 data only after nonzero burst", int'(last_good), 1);
                    mchk(int'(xm_cmd_len) == e, "R5 R3 chunk length", int'(xm_cmd_len), e);
                    mchk(xm_cmd_read == run_dir, "R5 chunk direction", int'(xm_cmd_read), int'(run_dir));
                    rem_m <= rem_m - int'(xm_cmd_len);
                    last_good <= 1'b0;
                    if (xm_cmd_read) begin
                        rd_left <= int'(xm_cmd_len); rd_pos <= 0; rd_sts <= 1'b0;
                    end
                end else begin
                    mchk(1'b0, "R5 command address", int'(xm_cmd_addr), int'(FIFO_A));
                end
            end

            // R6: stream ordering
            if (dn_tvalid) begin
                mchk(dn_tdata == pat(run_id, rx_idx), "R6 read byte order",
                     int'(dn_tdata), int'(pat(run_id, rx_idx)));
                rx_idx <= rx_idx + 1;
            end
            if (xm_wvalid && xm_wready) begin
                mchk(xm_wdata == pat(run_id, wr_idx), "R6 write byte order",
                     int'(xm_wdata), int'(pat(run_id, wr_idx)));
                wr_idx <= wr_idx + 1;
            end
            if (up_tvalid && up_tready) src_idx <= src_idx + 1;
        end
    end

    int checks = 0, fails = 0;
    logic finished = 1'b0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic d, input int total);
        int waited;
        @(negedge clk);
        run_id = run_id + 1; run_dir = d; run_total = total; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; start = 1'b1; dir = d; total_len = LEN_W'(total);
        @(negedge clk);
        start = 1'b0;
        if (total == 0) begin
            chk(o_done == 1'b1, "R8 zero total done", int'(o_done), 1);
            chk(cmd_count == 0, "R8 zero total no command", cmd_count, 0);
        end else begin
            waited = 0;
            while (!o_done && waited < 20000) begin
                @(negedge clk);
                waited = waited + 1;
            end
            chk(o_done == 1'b1, "R7 done reached", int'(o_done), 1);
            chk((d ? rx_idx : wr_idx) == total, "R7 bytes moved", d ? rx_idx : wr_idx, total);
            chk(rem_m == 0, "R7 nothing remaining", rem_m, 0);
        end
        @(negedge clk);
        chk(o_done == 1'b0, "R7 done single cycle", int'(o_done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!xm_cmd_valid && !o_done && !dn_tvalid && !up_tready, "R1 state in reset",
            int'({xm_cmd_valid, o_done, dn_tvalid, up_tready}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!xm_cmd_valid && !o_done && !dn_tvalid && !up_tready, "R1 state after reset",
            int'({xm_cmd_valid, o_done, dn_tvalid, up_tready}), 0);
        for (int d = 0; d < 2; d++) begin
            for (int t = 0; t <= 150; t++) run(d[0], t);
            run(d[0], 700);
            run(d[0], 1023);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + mchecks, fails + mfails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks + mchecks + 1, fails + mfails + 1);
            $finish;
        end
    end

endmodule